// File: doc/BRIEF.md
# Threshold-Launched Transmit Frame Buffer

This block collects an outgoing network frame that software pushes in one 32-bit word at a time. The first word of every frame is a header: its low 16 bits give the payload byte count, and its high 16 bits are already the first two bytes of the frame. Words are unpacked into a byte buffer, lowest byte first. Once the frame is in the buffer it is sent out on a byte-wide valid/ready stream. The frame is the buffered bytes after the 2-byte length field, optionally zero-padded to a minimum size.

A frame can be launched in two ways. Launch is automatic when a programmable fill threshold is met and the whole frame has arrived. Launch is manual when a send strobe is pulsed. While a frame streams out, the block shows busy and does not take new words. When a frame completes, a one-cycle transmit-empty event is raised. A header that declares an oversized payload raises a one-cycle transmit-error event instead of being stored.

Top module: `tx_thresh_fifo`

## Requirements
- R1: After reset, tx_valid, wr_busy, evt_tx_empty and evt_tx_error are low and the buffer is empty, so a send strobe starts nothing.
- R2: A word written into an empty buffer whose bits [15:0] exceed 2032 is discarded. evt_tx_error is high for exactly the one cycle after that write, and the buffer stays empty. A header of exactly 2032 raises no error.
- R3: Each accepted word takes the next 4 buffer bytes in the order bits [7:0], [15:8], [23:16], [31:24]. A word is stored only while at least 4 of the 2048 bytes are free.
- R4: When a stored word brings the fill to at least 32*thr_words+4 bytes, with thr_words below 63, and the frame is complete, tx_valid rises in the next cycle. It does not rise earlier. thr_words equal to 63 turns automatic launch off.
- R5: A frame is complete when the fill reaches length+16 bytes, plus 4 more when crc_auto is 0, capped at 2048.
- R6: A send_req pulse in an idle cycle with wr_valid low and a non-empty buffer launches the frame. With an empty buffer it is ignored.
- R7: The streamed frame is the buffer bytes from byte index 2 onward. Its length is min(length+14, 2046).
- R8: With pad_en set and that length below 60, zero bytes follow the data until 60 bytes have been sent.
- R9: After the last byte is taken, the buffer is empty and evt_tx_empty is high for exactly one cycle, with tx_valid low.
- R10: wr_busy is high while a frame streams. Words offered then are dropped and leave the buffer untouched.
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to append; in an empty buffer, bits [15:0] are the length |
| wr_busy | output | 1 | Frame streaming; writes are not taken |
| send_req | input | 1 | Manual launch strobe |
| thr_words | input | 6 | Launch threshold; 63 disables automatic launch |
| crc_auto | input | 1 | 1: no check bytes expected in the buffer |
| pad_en | input | 1 | Pad short frames with zeros to 60 bytes |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Sink accepts the byte |
| evt_tx_empty | output | 1 | One-cycle pulse after a frame is sent |
| evt_tx_error | output | 1 | One-cycle pulse for an oversized header |

## Verification
Frames are pushed with a mix of lengths, thresholds and crc_auto settings, so that the launch point falls at different word counts. Some of these cases separate the threshold gate from the completeness gate. Others separate the 16-byte and 20-byte completeness rules. A no-padding vector, a sub-60 padded vector and an exactly-60 padded vector tell padding apart from plain truncation. The full-buffer frame with the 2032 header and the 2033 header mark the length-limit boundary. Stalled sinks, a manually launched frame and writes offered during streaming cover hold, the manual path and busy rejection.

// File: rtl/tx_thresh_pkg.sv
package tx_thresh_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    localparam int unsigned WORD_BYTES     = 4;
    localparam int unsigned LEN_BYTES      = 2;
    localparam int unsigned ETH_HDR_BYTES  = 14;
    localparam int unsigned FCS_BYTES      = 4;
    localparam int unsigned COMPLETE_EXTRA = LEN_BYTES + ETH_HDR_BYTES;
    localparam int unsigned THR_OFF        = 63;
endpackage

// File: rtl/tx_thresh_store.sv
module tx_thresh_store #(
    parameter int unsigned DEPTH_BYTES = 2048,
    parameter int unsigned AW          = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-3:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rbyte
);
    localparam int unsigned DEPTH_WORDS = DEPTH_BYTES / tx_thresh_pkg::WORD_BYTES;

    logic [31:0] mem [DEPTH_WORDS];
    logic [31:0] rword;
    logic [7:0]  lanes [tx_thresh_pkg::WORD_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rword = mem[raddr[AW-1:2]];

    for (genvar g = 0; g < int'(tx_thresh_pkg::WORD_BYTES); g++) begin : g_lane
        assign lanes[g] = rword[8*g +: 8];
    end

    assign rbyte = lanes[raddr[1:0]];
endmodule

// File: rtl/tx_thresh_eval.sv
module tx_thresh_eval #(
    parameter int unsigned DEPTH_BYTES = 2048,
    parameter int unsigned FW          = 12,
    parameter int unsigned MIN_FRAME   = 60
) (
    input  logic [FW-1:0] fill,
    input  logic [15:0]   len,
    input  logic [5:0]    thr,
    input  logic          crc_auto,
    input  logic          pad_en,
    output logic          thr_hit,
    output logic          frame_done,
    output logic [FW-1:0] data_len,
    output logic [FW-1:0] out_len
);
    import tx_thresh_pkg::*;

    localparam int unsigned CW = 18;

    logic [CW-1:0] need_raw, need, thr_bytes, flen_raw, flen;

    always_comb begin
        need_raw  = CW'(len) + CW'(COMPLETE_EXTRA) + (crc_auto ? CW'(0) : CW'(FCS_BYTES));
        need      = (need_raw > CW'(DEPTH_BYTES)) ? CW'(DEPTH_BYTES) : need_raw;
        thr_bytes = CW'(thr) * CW'(8 * WORD_BYTES) + CW'(WORD_BYTES);
        thr_hit   = (thr != 6'(THR_OFF)) && (CW'(fill) >= thr_bytes);
        frame_done = CW'(fill) >= need;
        flen_raw  = CW'(len) + CW'(ETH_HDR_BYTES);
        flen      = (flen_raw > CW'(DEPTH_BYTES - LEN_BYTES)) ? CW'(DEPTH_BYTES - LEN_BYTES) : flen_raw;
        data_len  = FW'(flen);
        out_len   = (pad_en && (flen < CW'(MIN_FRAME))) ? FW'(MIN_FRAME) : FW'(flen);
    end
endmodule

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo #(
    parameter int unsigned DEPTH_BYTES = 2048,
    parameter int unsigned MIN_FRAME   = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_busy,
    input  logic        send_req,
    input  logic [5:0]  thr_words,
    input  logic        crc_auto,
    input  logic        pad_en,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        evt_tx_empty,
    output logic        evt_tx_error
);
    import tx_thresh_pkg::*;

    localparam int unsigned AW      = $clog2(DEPTH_BYTES);
    localparam int unsigned FW      = AW + 1;
    localparam int unsigned MAX_LEN = DEPTH_BYTES - COMPLETE_EXTRA;

    typedef struct packed {
        tx_state_e      state;
        logic [FW-1:0]  fill;
        logic [15:0]    len;
        logic [FW-1:0]  idx;
        logic [FW-1:0]  dlen;
        logic [FW-1:0]  olen;
        logic           empty_evt;
        logic           err_evt;
    } regs_t;

    regs_t st_d, st_q;

    logic          hdr_word, too_long, room, wr_en;
    logic [15:0]   len_wr;
    logic [FW-1:0] fill_wr;
    logic          thr_hit, frame_done;
    logic [FW-1:0] data_len, out_len;
    logic [7:0]    rbyte;
    logic [AW-1:0] raddr;

    assign hdr_word = (st_q.fill == '0);
    assign len_wr   = hdr_word ? wr_data[15:0] : st_q.len;
    assign fill_wr  = st_q.fill + FW'(WORD_BYTES);
    assign too_long = hdr_word && (wr_data[15:0] > 16'(MAX_LEN));
    assign room     = st_q.fill <= FW'(DEPTH_BYTES - WORD_BYTES);

    tx_thresh_eval #(
        .DEPTH_BYTES (DEPTH_BYTES),
        .FW          (FW),
        .MIN_FRAME   (MIN_FRAME)
    ) eval_i (
        .fill       (fill_wr),
        .len        (len_wr),
        .thr        (thr_words),
        .crc_auto   (crc_auto),
        .pad_en     (pad_en),
        .thr_hit    (thr_hit),
        .frame_done (frame_done),
        .data_len   (data_len),
        .out_len    (out_len)
    );

    always_comb begin
        st_d           = st_q;
        st_d.empty_evt = 1'b0;
        st_d.err_evt   = 1'b0;
        wr_en          = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (wr_valid) begin
                    if (too_long) begin
                        st_d.err_evt = 1'b1;
                    end else if (room) begin
                        wr_en     = 1'b1;
                        st_d.fill = fill_wr;
                        st_d.len  = len_wr;
                        if (thr_hit && frame_done) begin
                            st_d.state = ST_SEND;
                            st_d.idx   = '0;
                            st_d.dlen  = data_len;
                            st_d.olen  = out_len;
                        end
                    end
                end else if (send_req && !hdr_word) begin
                    st_d.state = ST_SEND;
                    st_d.idx   = '0;
                    st_d.dlen  = data_len;
                    st_d.olen  = out_len;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (st_q.idx == st_q.olen - FW'(1)) begin
                        st_d.state     = ST_IDLE;
                        st_d.fill      = '0;
                        st_d.idx       = '0;
                        st_d.empty_evt = 1'b1;
                    end else begin
                        st_d.idx = st_q.idx + FW'(1);
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr = st_q.idx[AW-1:0] + AW'(LEN_BYTES);

    tx_thresh_store #(
        .DEPTH_BYTES (DEPTH_BYTES),
        .AW          (AW)
    ) store_i (
        .clk   (clk),
        .we    (wr_en),
        .waddr (st_q.fill[AW-1:2]),
        .wdata (wr_data),
        .raddr (raddr),
        .rbyte (rbyte)
    );

    assign wr_busy      = (st_q.state == ST_SEND);
    assign tx_valid     = (st_q.state == ST_SEND);
    assign tx_data      = (st_q.idx < st_q.dlen) ? rbyte : 8'h00;
    assign evt_tx_empty = st_q.empty_evt;
    assign evt_tx_error = st_q.err_evt;
endmodule

// File: rtl/tx_thresh_chk.sv
module tx_thresh_chk #(
    parameter int unsigned FW          = 12,
    parameter int unsigned DEPTH_BYTES = 2048
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_busy,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          evt_tx_empty,
    input logic          evt_tx_error,
    input logic [FW-1:0] fill_now
);
    a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r9_empty_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_empty |-> ($past(tx_valid && tx_ready) && !tx_valid));

    a_r9_fill_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_empty |-> (fill_now == '0));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_empty |=> !evt_tx_empty);

    a_r2_error_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_error |-> $past(wr_valid && !wr_busy));

    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_now <= FW'(DEPTH_BYTES)) && (fill_now[1:0] == 2'b00));

    a_r10_busy_freezes_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && $past(wr_busy)) |-> $stable(fill_now));
endmodule

bind tx_thresh_fifo tx_thresh_chk #(
    .FW          (FW),
    .DEPTH_BYTES (DEPTH_BYTES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_busy      (wr_busy),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .evt_tx_empty (evt_tx_empty),
    .evt_tx_error (evt_tx_error),
    .fill_now     (st_q.fill)
);

// File: tb/tx_thresh_fifo_tb_top.sv
module tx_thresh_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_busy;
    logic        send_req = 1'b0;
    logic [5:0]  thr_words = 6'd0;
    logic        crc_auto = 1'b1;
    logic        pad_en = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        evt_tx_empty;
    logic        evt_tx_error;

    always #4 clk = ~clk;

    tx_thresh_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_busy(wr_busy), .send_req(send_req), .thr_words(thr_words),
        .crc_auto(crc_auto), .pad_en(pad_en), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .evt_tx_empty(evt_tx_empty),
        .evt_tx_error(evt_tx_error)
    );

    typedef struct packed {
        logic [15:0] len;
        logic [5:0]  thr;
        logic        crc;
        logic        pad;
        logic        man;
        logic        stall;
        logic        poke;
        logic [11:0] olen;
        logic [9:0]  nwords;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd20,   6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'd34,   10'd9},
        '{16'd10,   6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd60,   10'd8},
        '{16'd10,   6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'd24,   10'd8},
        '{16'd40,   6'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'd54,   10'd17},
        '{16'd100,  6'd63, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'd114,  10'd29},
        '{16'd46,   6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd60,   10'd16},
        '{16'd2032, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd2046, 10'd512},
        '{16'd0,    6'd1,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd60,   10'd9}
    };

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int b);
        return 8'((b * 7 + 3) & 255);
    endfunction

    function automatic logic [31:0] fw(input int k, input logic [15:0] len);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) begin
            int b = 4 * k + j;
            w[8*j +: 8] = (b == 0) ? len[7:0] : (b == 1) ? len[15:8] : fb(b);
        end
        return w;
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
    endtask

    task automatic pulse_send();
        @(negedge clk);
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        #1;
    endtask

    task automatic run_vector(input vec_t v);
        int early = 0;
        int dlen, cnt, bad_d, bad_p, bad_h, it, late;
        bit hold, busy_seen;
        logic [7:0] held, expb;
        thr_words = v.thr;
        crc_auto  = v.crc;
        pad_en    = v.pad;
        dlen = (int'(v.len) + 14 > 2046) ? 2046 : int'(v.len) + 14;
        for (int k = 0; k < int'(v.nwords); k++) begin
            wr(fw(k, v.len));
            if (k == 0) chk(evt_tx_error == 1'b0, "R2", "legal header raised error", int'(evt_tx_error), 0);
            if (k < int'(v.nwords) - 1 && tx_valid) early++;
        end
        chk(early == 0, "R4 R5", "launched before threshold and completeness", early, 0);
        if (v.man) begin
            chk(tx_valid == 1'b0, "R4", "disabled threshold launched", int'(tx_valid), 0);
            pulse_send();
            chk(tx_valid == 1'b1, "R6", "manual launch", int'(tx_valid), 1);
        end else begin
            chk(tx_valid == 1'b1, "R4 R5", "automatic launch", int'(tx_valid), 1);
        end
        cnt = 0; bad_d = 0; bad_p = 0; bad_h = 0; it = 0;
        hold = 1'b0; busy_seen = 1'b0; held = '0;
        while (cnt < int'(v.olen) && it < 20000) begin
            tx_ready = v.stall ? ((it % 3) != 0) : 1'b1;
            if (v.poke) begin
                wr_valid = (it == 4) || (it == 5);
                wr_data  = 32'h0000_0008;
            end
            #1;
            if (v.poke && it == 4) busy_seen = wr_busy;
            if (!tx_valid) break;
            if (hold && tx_data !== held) bad_h++;
            if (!tx_ready) begin
                hold = 1'b1;
                held = tx_data;
            end else begin
                hold = 1'b0;
                expb = (cnt < dlen) ? fb(cnt + 2) : 8'h00;
                if (tx_data !== expb) begin
                    if (cnt < dlen) bad_d++;
                    else bad_p++;
                end
                cnt++;
            end
            it++;
            @(negedge clk);
            #1;
        end
        wr_valid = 1'b0;
        tx_ready = 1'b1;
        chk(cnt == int'(v.olen), "R7 R8", "streamed byte count", cnt, int'(v.olen));
        chk(bad_d == 0, "R3 R7", "payload byte mismatches", bad_d, 0);
        if (int'(v.olen) > dlen) chk(bad_p == 0, "R8", "nonzero pad bytes", bad_p, 0);
        if (v.stall) chk(bad_h == 0, "R11", "byte changed while stalled", bad_h, 0);
        if (v.poke) chk(busy_seen, "R10", "busy while streaming", int'(busy_seen), 1);
        chk(evt_tx_empty == 1'b1 && tx_valid == 1'b0, "R9", "empty event after last byte",
            int'(evt_tx_empty), 1);
        @(negedge clk);
        #1;
        chk(evt_tx_empty == 1'b0, "R9", "empty event longer than one cycle", int'(evt_tx_empty), 0);
        if (v.poke) begin
            pulse_send();
            late = 0;
            for (int c = 0; c < 3; c++) begin
                if (tx_valid) late++;
                @(negedge clk);
                #1;
            end
            chk(late == 0, "R10", "write during busy was stored", late, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!tx_valid && !wr_busy && !evt_tx_empty && !evt_tx_error, "R1", "outputs during reset",
            int'({tx_valid, wr_busy, evt_tx_empty, evt_tx_error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!tx_valid && !wr_busy && !evt_tx_empty && !evt_tx_error, "R1", "outputs after reset",
            int'({tx_valid, wr_busy, evt_tx_empty, evt_tx_error}), 0);
        pulse_send();
        chk(tx_valid == 1'b0, "R1 R6", "send on empty buffer launched", int'(tx_valid), 0);

        for (int i = 0; i < 8; i++) begin
            run_vector(VECS[i]);
        end

        thr_words = 6'd0;
        wr({16'hABCD, 16'd2033});
        chk(evt_tx_error == 1'b1, "R2", "oversized header error", int'(evt_tx_error), 1);
        @(negedge clk);
        #1;
        chk(evt_tx_error == 1'b0, "R2", "error longer than one cycle", int'(evt_tx_error), 0);
        pulse_send();
        chk(tx_valid == 1'b0, "R2", "oversized header was stored", int'(tx_valid), 0);

        run_vector(VECS[2]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule